// File: doc/BRIEF.md
# UART DMA Handshake Ready Generator

This block produces the two active-low handshake lines that let a DMA controller service one UART channel: a transmit-ready line, which asks for more bytes to send, and a receive-ready line, which asks for received bytes to be collected. It does not hold any data. It only watches the fill levels and status flags that the channel's FIFOs, its holding registers and its receive timeout counter expose, and turns them into the two ready lines.

Three behaviours are chosen by two control bits. With the FIFOs switched off, the lines follow the single-byte holding registers. With the FIFOs on and DMA mode off, each line reports a simple empty or non-empty condition. With the FIFOs on and DMA mode on, transmit-ready stays asserted while any free slot remains, and receive-ready becomes a burst request with hysteresis. It asserts once the receive FIFO reaches its trigger level or a timeout is flagged, and it stays asserted until the FIFO has been drained to empty. Both outputs are registered.

Top module: `dma_ready_gen`

## Requirements
- R1: With fifoEn=0, rxRdyN is 0 when rxHoldFull=1 and 1 when rxHoldFull=0.
- R2: With fifoEn=0, txRdyN is 0 when txHoldFull=0 and 1 when txHoldFull=1. The dmaMode bit is ignored while fifoEn=0.
- R3: With fifoEn=1 and dmaMode=0, rxRdyN is 0 when rxLevel is 1 or more and 1 when rxLevel is 0.
- R4: With fifoEn=1 and dmaMode=0, txRdyN is 0 only when txLevel is 0, and 1 when txLevel is 1 or more.
- R5: With fifoEn=1 and dmaMode=1, rxRdyN goes to 0 when rxLevel is at or above rxTrigLevel, or when rxTimeout=1.
- R6: With fifoEn=1 and dmaMode=1, once rxRdyN is 0 it stays 0 while rxLevel is non-zero, even below the trigger level. It returns to 1 only when rxLevel reaches 0.
- R7: With fifoEn=1 and dmaMode=1, txRdyN is 0 while txLevel is below DEPTH and 1 when txLevel equals DEPTH (full).
- R8: In DMA mode, a set condition (trigger level reached or timeout) that arrives in the same cycle as an empty receive FIFO wins, and rxRdyN is 0.
- R9: Any change of fifoEn or dmaMode clears the receive hysteresis state. In the cycle of the change, a DMA-mode rxRdyN is therefore 1. From the next cycle on it follows the new mode's rules.
- R10: Both outputs are 1 while rst_n=0. Outside reset, each output reflects the inputs sampled at the previous rising clock edge, so there is one cycle of latency.
- R11: Each FIFO is DEPTH=128 bytes deep. rxLevel and txLevel are 8-bit counts from 0 to DEPTH, and rxTrigLevel lies from 1 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | FIFO enable control bit |
| dmaMode | input | 1 | DMA mode control bit |
| rxHoldFull | input | 1 | Receive holding register has a byte (FIFOs off) |
| txHoldFull | input | 1 | Transmit holding register has a byte (FIFOs off) |
| rxLevel | input | 8 | Receive FIFO fill count |
| rxTrigLevel | input | 8 | Receive trigger level |
| rxTimeout | input | 1 | Receive timeout flag |
| txLevel | input | 8 | Transmit FIFO fill count |
| rxRdyN | output | 1 | Active-low receive ready |
| txRdyN | output | 1 | Active-low transmit ready |

## Verification
The assertions assume that the fill counts never exceed DEPTH and that the trigger level is never 0. They check these conditions as assertions of their own. A zero trigger would make "empty" and "trigger reached" true together, and the release rule could not then be observed. The bench changes inputs only on falling edges and drives every level, trigger and mode combination inside those ranges. It never sets a trigger of 0, and the full-FIFO case uses exactly DEPTH.

// File: rtl/dma_ready_pkg.sv
package dma_ready_pkg;

  typedef enum logic [1:0] {
    MODE_NOFIFO = 2'd0,
    MODE_FIFO   = 2'd1,
    MODE_DMA    = 2'd2
  } rdyMode_e;

  typedef struct packed {
    rdyMode_e mode;
    logic     setReq;   // trigger reached or timeout
    logic     clrReq;   // receive FIFO empty
    logic     modeChg;  // control bits differ from last cycle
  } rdyStrobe_t;

endpackage

// File: rtl/dma_ready_ctrl.sv
module dma_ready_ctrl
  import dma_ready_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifoEn,
  input  logic             dmaMode,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrigLevel,
  input  logic             rxTimeout,
  output rdyStrobe_t       strobe
);

  logic prevFifoEn;
  logic prevDmaMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevFifoEn  <= 1'b0;
      prevDmaMode <= 1'b0;
    end else begin
      prevFifoEn  <= fifoEn;
      prevDmaMode <= dmaMode;
    end
  end

  always_comb begin
    if (!fifoEn)       strobe.mode = MODE_NOFIFO;
    else if (!dmaMode) strobe.mode = MODE_FIFO;
    else               strobe.mode = MODE_DMA;
    strobe.setReq  = (rxLevel >= rxTrigLevel) || rxTimeout;
    strobe.clrReq  = (rxLevel == '0);
    strobe.modeChg = (fifoEn != prevFifoEn) || (dmaMode != prevDmaMode);
  end

endmodule

// File: rtl/dma_ready_dp.sv
module dma_ready_dp
  import dma_ready_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rdyStrobe_t       strobe,
  input  logic             rxHoldFull,
  input  logic             txHoldFull,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  output logic             rxRdyN,
  output logic             txRdyN
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic burstFlag;
  logic burstNext;
  logic rxNext;
  logic txNext;

  // hysteresis flag: mode change clears, then set beats clear
  always_comb begin
    if (strobe.mode != MODE_DMA || strobe.modeChg) burstNext = 1'b0;
    else if (strobe.setReq)                         burstNext = 1'b1;
    else if (strobe.clrReq)                         burstNext = 1'b0;
    else                                            burstNext = burstFlag;
  end

  always_comb begin
    unique case (strobe.mode)
      MODE_NOFIFO: begin
        rxNext = !rxHoldFull;
        txNext = txHoldFull;
      end
      MODE_FIFO: begin
        rxNext = (rxLevel == '0);
        txNext = (txLevel != '0);
      end
      default: begin
        rxNext = !burstNext;
        txNext = (txLevel >= FULL_LVL);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burstFlag <= 1'b0;
      rxRdyN    <= 1'b1;
      txRdyN    <= 1'b1;
    end else begin
      burstFlag <= burstNext;
      rxRdyN    <= rxNext;
      txRdyN    <= txNext;
    end
  end

endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen
  import dma_ready_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifoEn,
  input  logic             dmaMode,
  input  logic             rxHoldFull,
  input  logic             txHoldFull,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrigLevel,
  input  logic             rxTimeout,
  input  logic [LVL_W-1:0] txLevel,
  output logic             rxRdyN,
  output logic             txRdyN
);

  rdyStrobe_t strobe;

  dma_ready_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifoEn     (fifoEn),
    .dmaMode    (dmaMode),
    .rxLevel    (rxLevel),
    .rxTrigLevel(rxTrigLevel),
    .rxTimeout  (rxTimeout),
    .strobe     (strobe)
  );

  dma_ready_dp #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .rxHoldFull(rxHoldFull),
    .txHoldFull(txHoldFull),
    .rxLevel   (rxLevel),
    .txLevel   (txLevel),
    .rxRdyN    (rxRdyN),
    .txRdyN    (txRdyN)
  );

endmodule

// File: rtl/dma_ready_checker.sv
module dma_ready_checker #(
  parameter int DEPTH = 128,
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifoEn,
  input logic             dmaMode,
  input logic             rxHoldFull,
  input logic             txHoldFull,
  input logic [LVL_W-1:0] rxLevel,
  input logic [LVL_W-1:0] rxTrigLevel,
  input logic             rxTimeout,
  input logic [LVL_W-1:0] txLevel,
  input logic             rxRdyN,
  input logic             txRdyN
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic chkPrevF, chkPrevD;
  logic dmaNow, dmaSteady, dmaEntry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chkPrevF <= 1'b0;
      chkPrevD <= 1'b0;
    end else begin
      chkPrevF <= fifoEn;
      chkPrevD <= dmaMode;
    end
  end

  assign dmaNow    = fifoEn && dmaMode;
  assign dmaSteady = dmaNow && chkPrevF && chkPrevD;
  assign dmaEntry  = dmaNow && !(chkPrevF && chkPrevD);

  // R11: input ranges the block relies on
  a_r11_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    rxLevel <= FULL_LVL && txLevel <= FULL_LVL && rxTrigLevel != '0 && rxTrigLevel <= FULL_LVL);

  a_r1_nofifo_rx: assert property (@(posedge clk) disable iff (!rst_n)
    !fifoEn |=> rxRdyN == !$past(rxHoldFull));

  a_r2_nofifo_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !fifoEn |=> txRdyN == $past(txHoldFull));

  a_r3_fifo_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoEn && !dmaMode) |=> rxRdyN == ($past(rxLevel) == '0));

  a_r4_fifo_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoEn && !dmaMode) |=> txRdyN == ($past(txLevel) != '0));

  a_r5_dma_set: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaSteady && (rxLevel >= rxTrigLevel || rxTimeout)) |=> !rxRdyN);

  a_r6_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaSteady && !rxRdyN && rxLevel != '0) |=> !rxRdyN);

  a_r6_dma_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaSteady && rxLevel == '0 && !rxTimeout) |=> rxRdyN);

  a_r7_dma_tx: assert property (@(posedge clk) disable iff (!rst_n)
    dmaNow |=> txRdyN == ($past(txLevel) == FULL_LVL));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaSteady && rxLevel == '0 && rxTimeout) |=> !rxRdyN);

  a_r9_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dmaEntry |=> rxRdyN);

  a_r10_reset_high: assert property (@(posedge clk)
    !rst_n |=> (rxRdyN && txRdyN) || !rst_n);

endmodule

bind dma_ready_gen dma_ready_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifoEn     (fifoEn),
  .dmaMode    (dmaMode),
  .rxHoldFull (rxHoldFull),
  .txHoldFull (txHoldFull),
  .rxLevel    (rxLevel),
  .rxTrigLevel(rxTrigLevel),
  .rxTimeout  (rxTimeout),
  .txLevel    (txLevel),
  .rxRdyN     (rxRdyN),
  .txRdyN     (txRdyN)
);

// File: tb/dma_ready_gen_test.sv
module dma_ready_gen_test;

  localparam int DEPTH = 128;
  localparam int LVL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifoEn = 1'b0, dmaMode = 1'b0;
  logic rxHoldFull = 1'b0, txHoldFull = 1'b0, rxTimeout = 1'b0;
  logic [LVL_W-1:0] rxLevel = '0, rxTrigLevel = 8'd8, txLevel = '0;
  logic rxRdyN, txRdyN;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_ready_gen #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .fifoEn(fifoEn), .dmaMode(dmaMode),
    .rxHoldFull(rxHoldFull), .txHoldFull(txHoldFull), .rxLevel(rxLevel),
    .rxTrigLevel(rxTrigLevel), .rxTimeout(rxTimeout), .txLevel(txLevel),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // inputs were applied at a falling edge; one rising edge registers them
  task automatic step();
    @(negedge clk);
  endtask

  task automatic test_reset();
    fifoEn = 1'b0; rxHoldFull = 1'b1; txHoldFull = 1'b0;
    rst_n = 1'b0;
    step(); step();
    check("R10 rx in reset", rxRdyN, 1'b1);
    check("R10 tx in reset", txRdyN, 1'b1);
    rst_n = 1'b1;
    step();
    check("R10 rx after reset", rxRdyN, 1'b0);
    check("R10 tx after reset", txRdyN, 1'b0);
  endtask

  task automatic test_nofifo();
    fifoEn = 1'b0; dmaMode = 1'b0;
    rxHoldFull = 1'b0; txHoldFull = 1'b1; rxLevel = 8'd50; txLevel = 8'd0;
    step();
    check("R1 rx empty hold", rxRdyN, 1'b1);
    check("R2 tx full hold", txRdyN, 1'b1);
    rxHoldFull = 1'b1; txHoldFull = 1'b0; dmaMode = 1'b1;
    step();
    check("R1 rx byte held", rxRdyN, 1'b0);
    check("R2 tx empty hold, dmaMode ignored", txRdyN, 1'b0);
    dmaMode = 1'b0;
    step();
  endtask

  task automatic test_fifo();
    fifoEn = 1'b1; dmaMode = 1'b0; rxHoldFull = 1'b1; txHoldFull = 1'b1;
    rxLevel = 8'd0; txLevel = 8'd0;
    step();
    check("R3 rx fifo empty", rxRdyN, 1'b1);
    check("R4 tx fifo empty", txRdyN, 1'b0);
    rxLevel = 8'd1; txLevel = 8'd1;
    step();
    check("R3 rx one byte", rxRdyN, 1'b0);
    check("R4 tx one byte", txRdyN, 1'b1);
    rxLevel = 8'd128; txLevel = 8'd127;
    step();
    check("R3 rx full", rxRdyN, 1'b0);
    check("R4 tx not empty", txRdyN, 1'b1);
  endtask

  task automatic test_dma_rx();
    fifoEn = 1'b1; dmaMode = 1'b1; rxTrigLevel = 8'd8; rxTimeout = 1'b0;
    rxLevel = 8'd3;
    step(); step();
    check("R5 below trigger", rxRdyN, 1'b1);
    rxLevel = 8'd7;
    step();
    check("R5 one below trigger", rxRdyN, 1'b1);
    rxLevel = 8'd8;
    step();
    check("R5 at trigger", rxRdyN, 1'b0);
    rxLevel = 8'd2;
    step();
    check("R6 held below trigger", rxRdyN, 1'b0);
    rxLevel = 8'd1;
    step();
    check("R6 held at one byte", rxRdyN, 1'b0);
    rxLevel = 8'd0;
    step();
    check("R6 released on empty", rxRdyN, 1'b1);
    rxLevel = 8'd2; rxTimeout = 1'b1;
    step();
    check("R5 timeout sets", rxRdyN, 1'b0);
    rxTimeout = 1'b0;
    step();
    check("R6 held after timeout", rxRdyN, 1'b0);
    rxLevel = 8'd0; rxTimeout = 1'b1;
    step();
    check("R8 set wins over empty (flag set)", rxRdyN, 1'b0);
    rxTimeout = 1'b0;
    step();
    check("R6 release", rxRdyN, 1'b1);
    rxTimeout = 1'b1;
    step();
    check("R8 set wins over empty (flag clear)", rxRdyN, 1'b0);
    rxTimeout = 1'b0;
    step();
    check("R6 release again", rxRdyN, 1'b1);
  endtask

  task automatic test_dma_tx();
    fifoEn = 1'b1; dmaMode = 1'b1;
    txLevel = 8'd0;
    step();
    check("R7 tx empty", txRdyN, 1'b0);
    txLevel = 8'd127;
    step();
    check("R7 tx one free slot", txRdyN, 1'b0);
    txLevel = 8'd128;
    step();
    check("R7 R11 tx full at 128", txRdyN, 1'b1);
    txLevel = 8'd64;
    step();
    check("R7 tx half", txRdyN, 1'b0);
  endtask

  task automatic test_mode_change();
    fifoEn = 1'b1; dmaMode = 1'b1; rxTrigLevel = 8'd8; rxTimeout = 1'b0;
    rxLevel = 8'd10;
    step();
    check("R5 set before switch", rxRdyN, 1'b0);
    rxLevel = 8'd5;
    step();
    check("R6 held before switch", rxRdyN, 1'b0);
    dmaMode = 1'b0;
    step();
    check("R3 fifo mode after switch", rxRdyN, 1'b0);
    dmaMode = 1'b1;
    step();
    check("R9 flag cleared on return", rxRdyN, 1'b1);
    step();
    check("R9 stays released below trigger", rxRdyN, 1'b1);
    dmaMode = 1'b0; rxLevel = 8'd20;
    step();
    dmaMode = 1'b1;
    step();
    check("R9 change cycle high", rxRdyN, 1'b1);
    step();
    check("R9 recomputed next cycle", rxRdyN, 1'b0);
    rxTrigLevel = 8'd128; rxLevel = 8'd128;
    step();
    check("R11 trigger at depth", rxRdyN, 1'b0);
  endtask

  initial begin
    fork
      begin
        step();
        test_reset();
        test_nofifo();
        test_fifo();
        test_dma_rx();
        test_dma_tx();
        test_mode_change();
        finished = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
          errors++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule